// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a two's-complement or unsigned integer into an IEEE 754 binary floating-point value. The source is held in a 64-bit operand. A 2-bit type selector says whether it is a signed or unsigned integer, and whether it is 32 or 64 bits wide. A precision select picks a double-precision result, or a single-precision result written back in the 64-bit double layout. A 2-bit rounding mode controls every conversion that can lose precision.

The block runs on every clock cycle and has no handshake. The converted value, a 5-bit class code, an inexact flag and a status-update enable are all registered, so each output appears one cycle after its operands. Any status register and any exception handling live outside the block; the enable tells that logic whether this conversion should touch them. A 32-bit source going to double precision is always exact, so for that case the enable stays low.

Top module: `i2f_convert`

## Requirements
- R1: The type selector is coded 0 = signed 32-bit, 1 = unsigned 32-bit, 2 = signed 64-bit, 3 = unsigned 64-bit. For both 32-bit types only bits 31:0 of the source are read, and bits 63:32 have no effect on any output.
- R2: A 32-bit source converted to double precision gives the exact value. Both the inexact flag and the status-update enable stay low, and the rounding mode has no effect on the result.
- R3: Any 64-bit source, and any single-precision conversion, drives the status-update enable high.
- R4: The rounding mode is coded 00 = nearest with ties to even, 01 = toward zero, 10 = toward +infinity, 11 = toward -infinity. The result equals the exact value rounded this way to the selected precision.
- R5: In single mode the result is the single-precision rounded value widened to the double layout. The exponent uses the double bias and the low 29 fraction bits are zero.
- R6: The inexact flag is high exactly when rounding discards nonzero bits of the magnitude.
- R7: The class code is 00010 for a zero result, 00100 for a positive normal result and 01000 for a negative normal result.
- R8: A zero source gives an all-zero result (+0.0) with the positive-zero class code.
- R9: A negative signed source gives a result whose sign bit is set and whose magnitude is the two's complement of the source. This includes the most negative 64-bit value, -2^63. An unsigned source never gives a negative result.
- R10: When rounding carries out of the fraction, the fraction becomes zero and the exponent goes up by one. For example, 2^64-1 rounded up becomes exactly 2^64.
- R11: All outputs are registered with one cycle of latency and are zero while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Integer operand |
| itype_i | input | 2 | Integer type selector |
| single_i | input | 1 | 1 = single-precision result in double layout, 0 = double |
| rmode_i | input | 2 | Rounding mode |
| res_o | output | 64 | Converted value in double layout |
| cls_o | output | 5 | Result class code |
| inexact_o | output | 1 | Rounding lost nonzero bits |
| upd_en_o | output | 1 | Conversion may update floating-point status |

## Verification
The bench builds the block with its default parameters: a 64-bit source, 32-bit narrow types, an 11-bit double exponent, a 52-bit double fraction and a 23-bit single fraction. These are the only values whose encodings can be cross-checked against the simulator's own real arithmetic. For every operand, the bench sweeps all 32 combinations of type, precision and rounding mode. The operands include zero, the extreme values of each type, exact ties just above 2^53 and 2^24, the carry-out at 2^64-1, and pseudo-random values scattered over the whole magnitude range. Together these reach every rounding branch, the carry renormalisation and the handling of junk in the upper source bits.

// File: rtl/i2f_pkg.sv
package i2f_pkg;

   typedef enum logic [1:0] {
      IT_S32 = 2'd0,
      IT_U32 = 2'd1,
      IT_S64 = 2'd2,
      IT_U64 = 2'd3
   } itype_e;

   typedef enum logic [1:0] {
      RND_NEAR = 2'd0,
      RND_ZERO = 2'd1,
      RND_UP   = 2'd2,
      RND_DOWN = 2'd3
   } rnd_e;

   localparam logic [4:0] CLS_POS_ZERO = 5'b00010;
   localparam logic [4:0] CLS_POS_NORM = 5'b00100;
   localparam logic [4:0] CLS_NEG_NORM = 5'b01000;

endpackage

// File: rtl/i2f_magnitude.sv
module i2f_magnitude #(
   parameter int SRC_W    = 64,
   parameter int NARROW_W = 32
) (
   input  logic [SRC_W-1:0] src_i,
   input  logic             is_signed_i,
   input  logic             is_narrow_i,
   output logic             neg_o,
   output logic [SRC_W-1:0] mag_o
);

   localparam int PAD_W = SRC_W - NARROW_W;

   logic             top_bit;
   logic [SRC_W-1:0] ext;

   always_comb begin
      if (is_narrow_i) begin
         top_bit = src_i[NARROW_W-1];
         ext     = {{PAD_W{is_signed_i & top_bit}}, src_i[NARROW_W-1:0]};
      end else begin
         top_bit = src_i[SRC_W-1];
         ext     = src_i;
      end
      neg_o = is_signed_i & top_bit;
      mag_o = neg_o ? (-ext) : ext;
   end

endmodule

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
   parameter int W     = 64,
   parameter int CNT_W = $clog2(W)
) (
   input  logic [W-1:0]     vec_i,
   output logic [CNT_W-1:0] cnt_o
);

   always_comb begin
      cnt_o = '0;
      for (int i = 0; i < W; i++) begin
         if (vec_i[i]) cnt_o = CNT_W'(W - 1 - i);
      end
   end

endmodule

// File: rtl/i2f_round.sv
module i2f_round
   import i2f_pkg::*;
#(
   parameter int BODY_W = 63,
   parameter int MAN_W  = 52,
   parameter int OUT_W  = 52
) (
   input  logic [BODY_W-1:0] body_i,
   input  logic [1:0]        rmode_i,
   input  logic              neg_i,
   output logic [OUT_W-1:0]  frac_o,
   output logic              carry_o,
   output logic              inexact_o
);

   localparam int DROP_W = BODY_W - MAN_W;

   if (DROP_W < 2) begin : g_bad_drop
      $error("i2f_round: at least two bits must lie below the kept fraction");
   end
   if (OUT_W < MAN_W) begin : g_bad_out
      $error("i2f_round: output field narrower than kept fraction");
   end

   logic [MAN_W-1:0] kept;
   logic             guard;
   logic             sticky;
   logic             inc;
   logic [MAN_W:0]   sum;

   assign kept   = body_i[BODY_W-1 -: MAN_W];
   assign guard  = body_i[DROP_W-1];
   assign sticky = |body_i[DROP_W-2:0];

   always_comb begin
      case (rnd_e'(rmode_i))
         RND_NEAR: inc = guard & (sticky | kept[0]);
         RND_ZERO: inc = 1'b0;
         RND_UP:   inc = (guard | sticky) & ~neg_i;
         RND_DOWN: inc = (guard | sticky) & neg_i;
         default:  inc = 1'b0;
      endcase
      sum       = {1'b0, kept} + {{MAN_W{1'b0}}, inc};
      carry_o   = sum[MAN_W];
      frac_o    = OUT_W'(sum[MAN_W-1:0]) << (OUT_W - MAN_W);
      inexact_o = guard | sticky;
   end

endmodule

// File: rtl/i2f_convert.sv
module i2f_convert
   import i2f_pkg::*;
#(
   parameter  int SRC_W    = 64,
   parameter  int NARROW_W = 32,
   parameter  int DP_EXP_W = 11,
   parameter  int DP_MAN_W = 52,
   parameter  int SP_MAN_W = 23,
   localparam int RES_W    = 1 + DP_EXP_W + DP_MAN_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SRC_W-1:0] src_i,
   input  logic [1:0]       itype_i,
   input  logic             single_i,
   input  logic [1:0]       rmode_i,
   output logic [RES_W-1:0] res_o,
   output logic [4:0]       cls_o,
   output logic             inexact_o,
   output logic             upd_en_o
);

   localparam int CNT_W   = $clog2(SRC_W);
   localparam int BODY_W  = SRC_W - 1;
   localparam int DP_BIAS = (1 << (DP_EXP_W - 1)) - 1;
   localparam int N_PREC  = 2;

   if (NARROW_W > DP_MAN_W + 1) begin : g_bad_exact
      $error("i2f_convert: narrow source must fit the double significand");
   end
   if (SP_MAN_W >= DP_MAN_W) begin : g_bad_prec
      $error("i2f_convert: single fraction must be narrower than double");
   end
   if (DP_BIAS + SRC_W >= (1 << DP_EXP_W) - 1) begin : g_bad_exp
      $error("i2f_convert: exponent field too small for source width");
   end
   if (NARROW_W >= SRC_W) begin : g_bad_narrow
      $error("i2f_convert: narrow type must be smaller than source");
   end

   logic                neg;
   logic [SRC_W-1:0]    mag;
   logic [CNT_W-1:0]    lz_cnt;
   logic [SRC_W-1:0]    norm;
   logic                nonzero;

   logic [DP_MAN_W-1:0] frac_a  [N_PREC];
   logic                carry_a [N_PREC];
   logic                inx_a   [N_PREC];

   logic [DP_MAN_W-1:0] frac_n;
   logic                carry_n;
   logic [DP_EXP_W-1:0] exp_n;
   logic [RES_W-1:0]    res_n;
   logic [4:0]          cls_n;
   logic                inexact_n;
   logic                upd_n;

   i2f_magnitude #(
      .SRC_W    (SRC_W),
      .NARROW_W (NARROW_W)
   ) mag_i (
      .src_i       (src_i),
      .is_signed_i (~itype_i[0]),
      .is_narrow_i (~itype_i[1]),
      .neg_o       (neg),
      .mag_o       (mag)
   );

   i2f_lzc #(
      .W     (SRC_W),
      .CNT_W (CNT_W)
   ) lzc_i (
      .vec_i (mag),
      .cnt_o (lz_cnt)
   );

   assign norm    = mag << lz_cnt;
   assign nonzero = norm[SRC_W-1];

   // index 0 rounds to double precision, index 1 to single precision
   for (genvar p = 0; p < N_PREC; p++) begin : g_prec
      localparam int MW = (p == 0) ? DP_MAN_W : SP_MAN_W;
      i2f_round #(
         .BODY_W (BODY_W),
         .MAN_W  (MW),
         .OUT_W  (DP_MAN_W)
      ) rnd_i (
         .body_i    (norm[BODY_W-1:0]),
         .rmode_i   (rmode_i),
         .neg_i     (neg),
         .frac_o    (frac_a[p]),
         .carry_o   (carry_a[p]),
         .inexact_o (inx_a[p])
      );
   end

   always_comb begin
      frac_n    = frac_a[single_i];
      carry_n   = carry_a[single_i];
      exp_n     = DP_EXP_W'(DP_BIAS + SRC_W - 1) - DP_EXP_W'(lz_cnt)
                  + DP_EXP_W'(carry_n);
      res_n     = nonzero ? {neg, exp_n, frac_n} : '0;
      inexact_n = nonzero & inx_a[single_i];
      upd_n     = itype_i[1] | single_i;
      if (!nonzero)  cls_n = CLS_POS_ZERO;
      else if (neg)  cls_n = CLS_NEG_NORM;
      else           cls_n = CLS_POS_NORM;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         res_o     <= '0;
         cls_o     <= '0;
         inexact_o <= 1'b0;
         upd_en_o  <= 1'b0;
      end else begin
         res_o     <= res_n;
         cls_o     <= cls_n;
         inexact_o <= inexact_n;
         upd_en_o  <= upd_n;
      end
   end

endmodule

// File: rtl/i2f_convert_chk.sv
module i2f_convert_chk
   import i2f_pkg::*;
#(
   parameter int SRC_W    = 64,
   parameter int NARROW_W = 32,
   parameter int RES_W    = 64,
   parameter int LOW_W    = 29
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [SRC_W-1:0] src_i,
   input logic [1:0]       itype_i,
   input logic             single_i,
   input logic [RES_W-1:0] res_o,
   input logic [4:0]       cls_o,
   input logic             inexact_o,
   input logic             upd_en_o
);

   // R2
   exact_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!itype_i[1] && !single_i) |=> (!upd_en_o && !inexact_o));

   // R3
   upd_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (itype_i[1] || single_i) |=> upd_en_o);

   // R6
   inexact_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inexact_o |-> upd_en_o);

   // R5
   single_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      single_i |=> (res_o[LOW_W-1:0] == '0));

   // R8
   zero_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (itype_i[1] ? (src_i == '0) : (src_i[NARROW_W-1:0] == '0))
      |=> (res_o == '0 && cls_o == CLS_POS_ZERO));

   // R7
   neg_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      res_o[RES_W-1] |-> (cls_o == CLS_NEG_NORM));

   // R9
   unsigned_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      itype_i[0] |=> !res_o[RES_W-1]);

endmodule

bind i2f_convert i2f_convert_chk #(
   .SRC_W    (SRC_W),
   .NARROW_W (NARROW_W),
   .RES_W    (RES_W),
   .LOW_W    (DP_MAN_W - SP_MAN_W)
) chk_i (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .src_i     (src_i),
   .itype_i   (itype_i),
   .single_i  (single_i),
   .res_o     (res_o),
   .cls_o     (cls_o),
   .inexact_o (inexact_o),
   .upd_en_o  (upd_en_o)
);

// File: tb/i2f_convert_tb_top.sv
`timescale 1ns/1ps
module i2f_convert_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src = '0;
   logic [1:0]  itype = '0;
   logic        single = 1'b0;
   logic [1:0]  rmode = '0;
   logic [63:0] res;
   logic [4:0]  cls;
   logic        inexact;
   logic        upd_en;

   int n_cmp = 0;
   int n_bad = 0;
   logic [63:0] st = 64'h9E37_79B9_7F4A_7C15;

   always #2.5 clk = ~clk;

   i2f_convert dut_i (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .src_i     (src),
      .itype_i   (itype),
      .single_i  (single),
      .rmode_i   (rmode),
      .res_o     (res),
      .cls_o     (cls),
      .inexact_o (inexact),
      .upd_en_o  (upd_en)
   );

   task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: src=%h type=%0d single=%0b mode=%0d actual=%h expected=%h",
                  tag, src, itype, single, rmode, act, exp);
      end
   endtask

   // Arithmetic reference built from the requirements
   function automatic void ref_conv(input logic [63:0] s, input logic [1:0] it,
                                    input logic sg, input logic [1:0] rm,
                                    output logic [63:0] r, output logic [4:0] c,
                                    output logic ix, output logic up);
      logic [63:0] ext, mag, q, rem, half, frac, mant;
      logic        ng, rup;
      int          k, p, sh;
      if (!it[1]) ext = it[0] ? {32'b0, s[31:0]} : {{32{s[31]}}, s[31:0]};
      else        ext = s;
      ng  = !it[0] && ext[63];
      mag = ng ? -ext : ext;
      p   = sg ? 23 : 52;
      up  = it[1] | sg;
      if (mag == 0) begin
         r = '0; c = 5'b00010; ix = 1'b0;
         return;
      end
      k = 0;
      while ((mag >> (k + 1)) != 0) k++;
      rem = 0; half = 0;
      if (k <= p) q = mag << (p - k);
      else begin
         sh   = k - p;
         q    = mag >> sh;
         rem  = mag - (q << sh);
         half = 64'd1 << (sh - 1);
      end
      case (rm)
         2'd0:    rup = (rem > half) || (rem == half && rem != 0 && q[0]);
         2'd1:    rup = 1'b0;
         2'd2:    rup = (rem != 0) && !ng;
         default: rup = (rem != 0) && ng;
      endcase
      q = q + {63'b0, rup};
      if (q == (64'd1 << (p + 1))) begin
         q = q >> 1;
         k++;
      end
      frac = q - (64'd1 << p);
      mant = sg ? (frac << 29) : frac;
      r    = {ng, 11'(k + 1023), mant[51:0]};
      c    = ng ? 5'b01000 : 5'b00100;
      ix   = rem != 0;
   endfunction

   task automatic apply(input logic [63:0] s, input logic [1:0] it,
                        input logic sg, input logic [1:0] rm);
      logic [63:0] er;
      logic [4:0]  ec;
      logic        eix, eup;
      longint      sx;
      src = s; itype = it; single = sg; rmode = rm;
      @(negedge clk);
      ref_conv(s, it, sg, rm, er, ec, eix, eup);
      if (sg)          cmp("R5 single value", res, er);
      else if (it[1])  cmp("R4 rounded double", res, er);
      else             cmp("R2 exact double", res, er);
      cmp("R7 class", {59'b0, cls}, {59'b0, ec});
      cmp("R6 inexact", {63'b0, inexact}, {63'b0, eix});
      if (eup) cmp("R3 update enable", {63'b0, upd_en}, 64'd1);
      else     cmp("R2 update enable", {63'b0, upd_en}, 64'd0);
      // independent encoding from simulator real arithmetic
      if (!sg && (!it[1] || (it == 2'd2 && rm == 2'd0))) begin
         if (!it[1]) sx = it[0] ? longint'({32'b0, s[31:0]}) : longint'({{32{s[31]}}, s[31:0]});
         else        sx = longint'(s);
         cmp(it[1] ? "R4 real cross-check" : "R2 real cross-check", res, $realtobits(real'(sx)));
      end
   endtask

   task automatic sweep(input logic [63:0] s);
      for (int it = 0; it < 4; it++)
         for (int sg = 0; sg < 2; sg++)
            for (int rm = 0; rm < 4; rm++)
               apply(s, 2'(it), 1'(sg), 2'(rm));
   endtask

   task automatic lit(input string tag, input logic [63:0] s, input logic [1:0] it,
                      input logic sg, input logic [1:0] rm, input logic [63:0] exp);
      src = s; itype = it; single = sg; rmode = rm;
      @(negedge clk);
      cmp(tag, res, exp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset values
      src = 64'hFFFF_FFFF_FFFF_FFFF; itype = 2'd3; single = 1'b1;
      @(negedge clk);
      cmp("R11 reset res", res, 64'd0);
      cmp("R11 reset flags", {57'b0, cls, inexact, upd_en}, 64'd0);
      rst_n = 1'b1;

      // R1 upper bits ignored for narrow types
      lit("R1 s32 junk", 64'hDEAD_BEEF_0000_0005, 2'd0, 1'b0, 2'd0, 64'h4014_0000_0000_0000);
      lit("R1 s32 neg junk", 64'h1234_5678_FFFF_FFFF, 2'd0, 1'b0, 2'd2, 64'hBFF0_0000_0000_0000);
      lit("R1 u32 junk", 64'h1234_5678_FFFF_FFFF, 2'd1, 1'b0, 2'd3, 64'h41EF_FFFF_FFE0_0000);
      // R9 most negative 64-bit
      lit("R9 min s64", 64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'd1, 64'hC3E0_0000_0000_0000);
      lit("R9 same bits unsigned", 64'h8000_0000_0000_0000, 2'd3, 1'b0, 2'd1, 64'h43E0_0000_0000_0000);
      // R10 carry renormalisation
      lit("R10 carry double", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd0, 64'h43F0_0000_0000_0000);
      lit("R10 no carry trunc", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b0, 2'd1, 64'h43EF_FFFF_FFFF_FFFF);
      lit("R10 single trunc", 64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 1'b1, 2'd1, 64'h43EF_FFFF_E000_0000);
      // R4 ties and directed modes
      lit("R4 tie to even", 64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'd0, 64'h4340_0000_0000_0000);
      lit("R4 toward +inf", 64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'd2, 64'h4340_0000_0000_0001);
      // R8 zero
      lit("R8 zero", 64'h0, 2'd2, 1'b1, 2'd2, 64'h0);

      // full combination sweeps
      sweep(64'h0);
      sweep(64'h1);
      sweep(64'hFFFF_FFFF_FFFF_FFFF);
      sweep(64'h8000_0000_0000_0000);
      sweep(64'h7FFF_FFFF_FFFF_FFFF);
      sweep(64'h0000_0000_8000_0000);
      sweep(64'h0000_0000_7FFF_FFFF);
      sweep(64'hFFFF_FFFF_0000_0000);
      sweep(64'h0020_0000_0000_0001);
      sweep(64'h0020_0000_0000_0003);
      sweep(64'h0000_0000_0100_0001);
      sweep(64'h0000_0000_0100_0003);
      sweep(64'hFFFF_FFFF_FEFF_FFFF);
      sweep(64'h0000_0000_00FF_FFFF);
      sweep(64'h0000_0000_01FF_FFFF);
      sweep(64'hFFE0_0000_0000_0001);
      for (int n = 0; n < 120; n++) begin
         st = st ^ (st << 13);
         st = st ^ (st >> 7);
         st = st ^ (st << 17);
         sweep(st >> st[5:0]);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule